// File: doc/BRIEF.md
# Serial Count BCD Totalizer

This block turns a serial pulse train, whose length is proportional to a measured magnitude, into a signed decimal value ready for display latches. Each rising edge of the serial input, after a synchronizer, adds one to a chain of BCD decade counters. A carry out of the most significant active decade sets a single leading "1" digit, so the largest value it can hold is a 1 followed by nines. The data moves in one direction only: pulses in, coded digits out.

A mode input, captured when a conversion begins, selects one of two resolutions. The high-resolution mode uses all `NDEC` decades. The low-resolution mode uses `NDEC-1` decades and shows the unused lowest-weight position as blank. A count past full scale raises a sticky overflow flag. While the flag is set, every active decade shows the code 1100, which is never a valid BCD digit. The leading-digit code does not change on overflow and also carries the polarity bit. A synchronous clear starts each new conversion.

Top module: `serial_bcd_totalizer`

## Requirements
- R1: Each decade nibble holds a value from 0 to 9. The count rises by exactly one for each rising edge of `pulse_i`, and the new value appears on the outputs three clock edges after the first edge that samples `pulse_i` high.
- R2: A carry ripples through every decade that holds 9 in the same cycle. A carry out of the top active decade sets `lead_o[0]`.
- R3: `hi_res_i` is captured on reset and on every clear. When it is low, decades 0 to NDEC-2 count and full scale is 2·10^(NDEC-1)−1 (19,999 at the default). When it is high, all NDEC decades count and full scale is 2·10^NDEC−1 (199,999).
- R4: One count past full scale sets `ovf_o`. While `ovf_o` is set, every active decade nibble reads 1100.
- R5: The leading-digit code `lead_o` is not affected by overflow. Bit 0 is the leading 1, bit 1 is the sign, and bits 3:2 are always 0.
- R6: Once `ovf_o` is set, it stays set until the next clear, even if more pulses arrive.
- R7: `clr_i` synchronously zeroes all decades, the leading digit and the overflow flag. If a counting edge falls in the same cycle as a clear, that edge is lost.
- R8: In low-resolution mode, nibble NDEC-1 of `digits_o` reads 1111 (blank), whether or not overflow is set.
- R9: `lead_o[1]` equals `neg_i` as it was one cycle earlier: 1 means negative, 0 means positive.
- R10: After reset, the outputs read as follows:
  - all active nibbles read 0;
  - `lead_o` is 0;
  - `ovf_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_i | input | 1 | Conversion start: clears the count and captures the mode |
| hi_res_i | input | 1 | Resolution select, 1 = all NDEC decades |
| pulse_i | input | 1 | Asynchronous serial count input |
| neg_i | input | 1 | Polarity, 1 = negative |
| digits_o | output | 4*NDEC | Coded decade nibbles, nibble i has weight 10^i |
| lead_o | output | 4 | Leading-digit code: bit 0 = leading 1, bit 1 = sign |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
Two events can land on the same clock edge:
- a counting edge and a conversion-start clear;
- the final carry through all-nines decades and the setting of the overflow flag.

The bench provokes the first case by placing the clear exactly on the edge at which a synchronized rise is detected. It then requires a zero count, with the pulse lost. For the second case, the bench counts through full scale in both modes, using short and long pulse shapes. It checks the step from 1 followed by nines into overflow against a behavioural count model, every cycle.

// File: rtl/bcd_tot_pkg.sv
// Package: shared nibble type and display codes for the totalizer.
// Assumes: the consumers use 4-bit BCD nibbles, with 1100 and 1111 as
// non-numeric marker codes.
package bcd_tot_pkg;
    typedef logic [3:0] nib_t;
    localparam nib_t NIB_OVER  = 4'b1100;  // decade shown on overflow
    localparam nib_t NIB_BLANK = 4'b1111;  // unused decade position
    localparam nib_t NIB_NINE  = 4'd9;
endpackage

// File: rtl/pulse_edge_sync.sv
// Module: pulse_edge_sync
// Brings an asynchronous pulse into the clock domain through STAGES flops.
// Emits a one-cycle strobe for each synchronized rising edge.
// Assumes: pulses stay high and low for at least one clock period each.
module pulse_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES:0] chain_q;

    // Shift the input through the synchronizer and one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-1:0], async_i};
    end

    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/bcd_decade.sv
// Module: bcd_decade
// One BCD decade counter. It steps on inc_i, wraps from 9 to 0, and
// raises carry_o in the same cycle as it wraps.
// Assumes: clr_i has priority over inc_i.
module bcd_decade
    import bcd_tot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output nib_t digit_o,
    output logic carry_o
);
    nib_t digit_q;

    // Count one step per increment, wrapping after nine.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)  digit_q <= '0;
        else if (inc_i)       digit_q <= (digit_q == NIB_NINE) ? 4'd0 : digit_q + 4'd1;
    end

    assign digit_o = digit_q;
    assign carry_o = inc_i && (digit_q == NIB_NINE);

    p_digit_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        digit_q <= NIB_NINE);

    p_wrap_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i && digit_q == NIB_NINE) |=> (digit_q == 4'd0));
endmodule

// File: rtl/serial_bcd_totalizer.sv
// Module: serial_bcd_totalizer (top)
// Totals synchronized serial pulses into a BCD decade chain with a leading
// "1" digit, a sticky overflow and a sign bit, then codes the digits for display.
// Assumes: NDEC >= 2, and the mode is changed only together with clr_i.
module serial_bcd_totalizer
    import bcd_tot_pkg::*;
#(
    parameter int NDEC   = 5,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic            hi_res_i,
    input  logic            pulse_i,
    input  logic            neg_i,
    output logic [4*NDEC-1:0] digits_o,
    output logic [3:0]      lead_o,
    output logic            ovf_o
);
    localparam int TOP = NDEC - 1;

    logic            rise;
    logic            mode_q;
    logic            lead_q;
    logic            ovf_q;
    logic            sign_q;
    logic            lead_carry;
    logic [NDEC-1:0] c_in;
    logic [NDEC-1:0] c_out;
    nib_t            dig [NDEC];

    pulse_edge_sync #(.STAGES(STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pulse_i),
        .rise_o  (rise)
    );

    // Build the decade chain; the top decade joins only in high-resolution mode.
    for (genvar i = 0; i < NDEC; i++) begin : g_dec
        if (i == 0) begin : g_first
            assign c_in[i] = rise;
        end else if (i == TOP) begin : g_top
            assign c_in[i] = mode_q & c_out[i-1];
        end else begin : g_mid
            assign c_in[i] = c_out[i-1];
        end

        bcd_decade u_dec (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_i   (clr_i),
            .inc_i   (c_in[i]),
            .digit_o (dig[i]),
            .carry_o (c_out[i])
        );

        if (i == TOP) begin : g_code_top
            assign digits_o[4*i +: 4] = !mode_q ? NIB_BLANK : (ovf_q ? NIB_OVER : dig[i]);
        end else begin : g_code
            assign digits_o[4*i +: 4] = ovf_q ? NIB_OVER : dig[i];
        end
    end

    assign lead_carry = mode_q ? c_out[TOP] : c_out[TOP-1];

    // Capture the resolution mode at reset and at each conversion start.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) mode_q <= hi_res_i;
    end

    // Leading digit and sticky overflow, driven by carry out of the top active decade.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            lead_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else if (lead_carry) begin
            lead_q <= 1'b1;
            if (lead_q) ovf_q <= 1'b1;
        end
    end

    // Register the polarity for the leading-digit code.
    always_ff @(posedge clk) begin
        if (!rst_n) sign_q <= 1'b0;
        else        sign_q <= neg_i;
    end

    assign lead_o = {2'b00, sign_q, lead_q};
    assign ovf_o  = ovf_q;

    p_overflow_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (digits_o[3:0] == NIB_OVER));

    p_lead_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (lead_o[0] && lead_o[3:2] == 2'b00));

    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !clr_i) |=> ovf_o);

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!ovf_o && !lead_o[0] && digits_o[3:0] == 4'd0));

    p_lowres_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q |-> (digits_o[4*TOP +: 4] == NIB_BLANK));

    p_sign_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (lead_o[1] == $past(neg_i)));
endmodule

// File: tb/sim_serial_bcd_totalizer.sv
module sim_serial_bcd_totalizer;
    localparam int CLK_PERIOD = 10;
    localparam int NDEC       = 3;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic hi_res = 1'b0;
    logic pin = 1'b0;
    logic neg = 1'b0;
    logic [4*NDEC-1:0] digits;
    logic [3:0]        lead;
    logic              ovf;

    int n_checks = 0;
    int n_fail   = 0;

    serial_bcd_totalizer #(.NDEC(NDEC), .STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .hi_res_i(hi_res),
        .pulse_i(pin), .neg_i(neg), .digits_o(digits), .lead_o(lead), .ovf_o(ovf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference: an integer count plus pulse-sample history.
    int   m_cnt = 0;
    bit   m_ovf = 0;
    bit   m_mode = 0;
    bit   m_sign = 0;
    bit   h0 = 0, h1 = 0, h2 = 0;
    bit   started = 0;

    function automatic int pow10(input int e);
        int r = 1;
        for (int k = 0; k < e; k++) r = r * 10;
        return r;
    endfunction

    always @(posedge clk) begin
        bit r;
        started = 1;
        r = h1 & ~h2;
        if (!rst_n) begin
            m_cnt = 0; m_ovf = 0; m_mode = hi_res; m_sign = 0;
            h0 = 0; h1 = 0; h2 = 0;
        end else begin
            if (clr) begin
                m_cnt = 0; m_ovf = 0; m_mode = hi_res;
            end else if (r) begin
                m_cnt = m_cnt + 1;
            end
            if (m_cnt >= 2 * pow10(m_mode ? NDEC : NDEC - 1)) m_ovf = 1;
            m_sign = neg;
            h2 = h1; h1 = h0; h0 = pin;
        end
    end

    function automatic logic [4*NDEC-1:0] exp_digits();
        logic [4*NDEC-1:0] v;
        for (int i = 0; i < NDEC; i++) begin
            if (!m_mode && i == NDEC - 1) v[4*i +: 4] = 4'hF;
            else if (m_ovf)               v[4*i +: 4] = 4'hC;
            else                          v[4*i +: 4] = 4'((m_cnt / pow10(i)) % 10);
        end
        return v;
    endfunction

    function automatic logic [3:0] exp_lead();
        int n = m_mode ? NDEC : NDEC - 1;
        bit l = m_ovf ? 1'b1 : ((m_cnt / pow10(n)) != 0);
        return {2'b00, m_sign, l};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, expv, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (started) begin
            chk("R1/R4/R8 digits", 32'(digits), 32'(exp_digits()));
            chk("R5/R9 lead code", 32'(lead), 32'(exp_lead()));
            chk("R6 overflow", 32'(ovf), 32'(m_ovf));
        end
    end

    task automatic pulse(input int hi_c, input int lo_c);
        pin = 1'b1;
        repeat (hi_c) @(negedge clk);
        pin = 1'b0;
        repeat (lo_c) @(negedge clk);
    endtask

    task automatic burst(input int n);
        for (int k = 0; k < n; k++) begin
            if (k % 7 == 3) pulse(3, 2);
            else            pulse(1, 1);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic conv_start(input bit mode);
        hi_res = mode;
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state (low-resolution mode, top nibble blank)
        chk("R10 reset digits", 32'(digits), 32'h00F00);
        chk("R10 reset lead", 32'(lead), 32'h0);
        chk("R10 reset ovf", 32'(ovf), 32'h0);

        // R1: first pulse appears three edges after being sampled
        pin = 1'b1;
        @(negedge clk); pin = 1'b0;       // sampled at edge 1
        @(negedge clk);
        chk("R1 not yet counted", 32'(digits[3:0]), 32'h0);
        @(negedge clk);                     // edge 3 passed
        chk("R1 count after three edges", 32'(digits[3:0]), 32'h1);

        // R2, R3: count to full scale in low-resolution mode (199)
        burst(198);
        chk("R3 low full scale digits", 32'(digits), 32'hF99);
        chk("R2 lead set by carry", 32'(lead[0]), 32'h1);

        // R4, R5: one more pulse overflows; lead code kept
        burst(1);
        chk("R4 overflow codes", 32'(digits), 32'hFCC);
        chk("R5 lead kept on overflow", 32'(lead), 32'h1);

        // R6: sticky while more pulses arrive
        burst(12);
        chk("R6 still overflowed", 32'(ovf), 32'h1);

        // R9: sign follows polarity
        neg = 1'b1;
        @(negedge clk);
        chk("R9 negative sign", 32'(lead[1]), 32'h1);

        // R7: clear, then clear colliding with a detected rise
        conv_start(1'b0);
        chk("R7 cleared ovf", 32'(ovf), 32'h0);
        burst(5);
        pin = 1'b1; @(negedge clk);         // sampled at edge j
        pin = 1'b0; @(negedge clk);         // edge j+1
        clr = 1'b1; @(negedge clk);         // edge j+2: rise and clear
        clr = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 clear wins over edge", 32'(digits), 32'hF00);
        chk("R8 blank top nibble", 32'(digits[4*NDEC-1 -: 4]), 32'hF);

        // R3: high-resolution mode reaches 1999, then overflows
        neg = 1'b0;
        conv_start(1'b1);
        burst(1999);
        chk("R3 high full scale digits", 32'(digits), 32'h999);
        chk("R3 high lead", 32'(lead), 32'h1);
        burst(1);
        chk("R4 high overflow codes", 32'(digits), 32'hCCC);
        chk("R6 high ovf", 32'(ovf), 32'h1);

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule